// File: doc/BRIEF.md
# Configurable Round-Robin Hub Slot Arbiter

This block shares a single memory port among up to 16 processor cores by handing out time slots in a strict rotation. A slot counter steps one position per clock through a ring of 1, 2, 4, 8 or 16 positions. The core whose index matches the current position owns that clock's slot. Each clock the arbiter presents a registered one-hot grant, together with the slot index that grant belongs to. Because the ring length is always a power of two, a core's slot spacing always divides the 16-clock spacing of the largest ring. Code timed for the 16-core ring therefore keeps working on a smaller ring: it simply leaves the extra slots unused.

A built-in start allocator hands out core IDs. A start request receives the lowest free ID below the configured limit, or a failure flag once every ID in the ring is taken. Stopping a core returns its ID to the pool. The ring length is written as a 3-bit code. The new length waits until the counter next returns to zero, and a write that would leave a running core outside the new ring is refused with an error pulse.

In the optional spare mode, a slot whose owner cannot use it goes to the lowest-numbered eligible core marked in a spare mask. The owner of a slot always keeps priority in its own slot. A granted memory operation occupies its core for a fixed number of clocks (8 by default), and the arbiter grants that core nothing more until the operation is over.

Top module: `hub_ring_arb`

## Requirements
- R1: After a synchronous reset, `ring_len` reads 16, `run_mask` reads 0x0001 (only core 0 running), `slot_idx` reads 0 and `grant` is all zeros.
- R2: The slot index steps by one every clock from 0 up to ring length minus 1 and then returns to 0, so it never reaches the ring length.
- R3: `grant` has at most one bit set. With spare mode off, a set bit is always bit `slot_idx` of the same cycle.
- R4: A core that is not running, or whose index is not below the active ring length, is never granted.
- R5: A start request that finds a free ID below the limit pulses `start_ack` in the next cycle, with the lowest such ID on `start_id`. When no ID is free, the request instead pulses `start_fail` and the running set is unchanged.
- R6: A stop request clears that core's `run_mask` bit, so a later start can hand out the same ID again.
- R7: The ring-size code is decoded as 0→1, 1→2, 2→4, 3→8 and 4→16 cores. The codes 5, 6 and 7 all select 16 cores.
- R8: A ring-size write that would leave a running core at or above the new length is ignored: `cfg_err` pulses in the next cycle and `ring_len` stays unchanged.
- R9: An accepted ring-size change takes effect only when the slot counter wraps to 0. Every wrap therefore happens from the last position of either the old ring or the new ring.
- R10: With `spare_en` high, a slot whose owner is not eligible goes to the lowest-numbered running, requesting, non-busy core that is set in `spare_mask`. An eligible owner still receives its own slot.
- R11: After a core is granted, it is not granted again for BUSY clocks (8), so any two grants to the same core are at least 8 cycles apart.
- R12: `grant` and `slot_idx` are registered together and describe the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Ring-size write strobe |
| cfg_code | input | 3 | Ring-size code (see R7) |
| cfg_err | output | 1 | Pulse: the last write was refused |
| ring_len | output | 5 | Active ring length (1..16) |
| start_req | input | 1 | Request to start a core |
| start_ack | output | 1 | Pulse: start succeeded |
| start_fail | output | 1 | Pulse: no free ID within the limit |
| start_id | output | 4 | ID given by the last successful start |
| stop_req | input | 1 | Request to stop a core |
| stop_id | input | 4 | Core to stop |
| run_mask | output | 16 | Running cores |
| hub_req | input | 16 | Per-core memory request (level) |
| spare_en | input | 1 | Enable spare-slot reuse |
| spare_mask | input | 16 | Cores allowed to take spare slots |
| grant | output | 16 | One-hot slot grant |
| slot_idx | output | 4 | Slot index that `grant` belongs to |

## Verification
The assertions assume that reset is held high for the first clocks. They also assume that `start_req` and `stop_req` are single-cycle strobes, and that `spare_en` may change at any time. The owner-only grant property looks at the previous cycle's `spare_en` for exactly that reason. `hub_req` is treated as a level that the arbiter may sample on any clock. The bench changes every input on the falling edge only and holds each strobe for exactly one cycle. It also never stops a core while that core's request is being measured, so grant spacing reflects the arbiter alone.

// File: rtl/hub_ring_pkg.sv
package hub_ring_pkg;

  // Decode a ring-size code into a core count, clamped to 2**lg_max.
  function automatic int unsigned ring_len(input logic [2:0] code,
                                           input int unsigned lg_max);
    int unsigned e;
    e = {29'd0, code};
    if (e > lg_max) e = lg_max;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/ring_slot_ctr.sv
module ring_slot_ctr #(
  parameter int LGN = 4,
  localparam int N  = 1 << LGN,
  localparam int LW = LGN + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_code,
  input  logic [N-1:0]   run_mask,
  output logic [LGN-1:0] slot_q,
  output logic [LW-1:0]  act_len,
  output logic [LW-1:0]  lim_len,
  output logic           cfg_err
);
  logic [LW-1:0] pend_len;
  logic          pend_v;
  logic [LW-1:0] new_len;
  logic          strand;
  logic          wrap;
  logic          accept;

  always_comb begin
    new_len = LW'(hub_ring_pkg::ring_len(cfg_code, LGN));
    strand  = 1'b0;
    for (int i = 0; i < N; i++)
      if (run_mask[i] && (i >= int'(new_len))) strand = 1'b1;
    accept  = cfg_we && !strand;
    wrap    = ({1'b0, slot_q} == (act_len - LW'(1)));
    lim_len = (pend_v && (pend_len < act_len)) ? pend_len : act_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      act_len  <= LW'(N);
      pend_len <= LW'(N);
      pend_v   <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_we && strand;
      if (accept) begin
        pend_v   <= 1'b1;
        pend_len <= new_len;
      end
      if (wrap) begin
        slot_q <= '0;
        if (pend_v) begin
          act_len <= pend_len;
          if (!accept) pend_v <= 1'b0;
        end
      end else begin
        slot_q <= slot_q + LGN'(1);
      end
    end
  end
endmodule

// File: rtl/core_allocator.sv
module core_allocator #(
  parameter int LGN = 4,
  localparam int N  = 1 << LGN,
  localparam int LW = LGN + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_req,
  input  logic           stop_req,
  input  logic [LGN-1:0] stop_id,
  input  logic [LW-1:0]  lim_len,
  output logic [N-1:0]   run_q,
  output logic           start_ack,
  output logic           start_fail,
  output logic [LGN-1:0] start_id
);
  logic           free_found;
  logic [LGN-1:0] free_id;
  logic [N-1:0]   run_nxt;

  always_comb begin
    free_found = 1'b0;
    free_id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!run_q[i] && (i < int'(lim_len))) begin
        free_found = 1'b1;
        free_id    = LGN'(i);
      end
    end
    run_nxt = run_q;
    if (stop_req) run_nxt[stop_id] = 1'b0;
    if (start_req && free_found) run_nxt[free_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= N'(1);
      start_ack  <= 1'b0;
      start_fail <= 1'b0;
      start_id   <= '0;
    end else begin
      run_q      <= run_nxt;
      start_ack  <= start_req && free_found;
      start_fail <= start_req && !free_found;
      if (start_req && free_found) start_id <= free_id;
    end
  end
endmodule

// File: rtl/slot_grant_sel.sv
module slot_grant_sel #(
  parameter int LGN  = 4,
  parameter int BUSY = 8,
  localparam int N   = 1 << LGN,
  localparam int LW  = LGN + 1,
  localparam int BW  = $clog2(BUSY)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LGN-1:0] slot_q,
  input  logic [LW-1:0]  act_len,
  input  logic [N-1:0]   run_mask,
  input  logic [N-1:0]   req,
  input  logic           spare_en,
  input  logic [N-1:0]   spare_mask,
  output logic [N-1:0]   grant_q,
  output logic [LGN-1:0] slot_o
);
  logic [N-1:0] busy;
  logic [N-1:0] elig;
  logic [N-1:0] pick;

  for (genvar g = 0; g < N; g++) begin : g_core
    logic [BW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (pick[g])       cnt <= BW'(BUSY - 1);
      else if (cnt != '0)     cnt <= cnt - BW'(1);
    end
    assign busy[g] = (cnt != '0);
    assign elig[g] = req[g] && run_mask[g] && !busy[g] && (g < int'(act_len));
  end

  always_comb begin
    pick = '0;
    if (elig[slot_q]) begin
      pick[slot_q] = 1'b1;
    end else if (spare_en) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (elig[i] && spare_mask[i]) begin
          pick    = '0;
          pick[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      slot_o  <= '0;
    end else begin
      grant_q <= pick;
      slot_o  <= slot_q;
    end
  end
endmodule

// File: rtl/hub_ring_arb.sv
module hub_ring_arb #(
  parameter int LGN  = 4,
  parameter int BUSY = 8,
  localparam int N   = 1 << LGN,
  localparam int LW  = LGN + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_code,
  output logic           cfg_err,
  output logic [LW-1:0]  ring_len,
  input  logic           start_req,
  output logic           start_ack,
  output logic           start_fail,
  output logic [LGN-1:0] start_id,
  input  logic           stop_req,
  input  logic [LGN-1:0] stop_id,
  output logic [N-1:0]   run_mask,
  input  logic [N-1:0]   hub_req,
  input  logic           spare_en,
  input  logic [N-1:0]   spare_mask,
  output logic [N-1:0]   grant,
  output logic [LGN-1:0] slot_idx
);
  logic [LGN-1:0] slot_q;
  logic [LW-1:0]  act_len;
  logic [LW-1:0]  lim_len;

  ring_slot_ctr #(.LGN(LGN)) u_ctr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .run_mask(run_mask), .slot_q(slot_q), .act_len(act_len),
    .lim_len(lim_len), .cfg_err(cfg_err)
  );

  core_allocator #(.LGN(LGN)) u_alloc (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .stop_id(stop_id), .lim_len(lim_len), .run_q(run_mask),
    .start_ack(start_ack), .start_fail(start_fail), .start_id(start_id)
  );

  slot_grant_sel #(.LGN(LGN), .BUSY(BUSY)) u_sel (
    .clk(clk), .rst(rst), .slot_q(slot_q), .act_len(act_len),
    .run_mask(run_mask), .req(hub_req), .spare_en(spare_en),
    .spare_mask(spare_mask), .grant_q(grant), .slot_o(slot_idx)
  );

  assign ring_len = act_len;
endmodule

// File: rtl/hub_ring_chk.sv
module hub_ring_chk #(
  parameter int LGN  = 4,
  parameter int BUSY = 8,
  localparam int N   = 1 << LGN,
  localparam int LW  = LGN + 1,
  localparam int SW  = $clog2(BUSY + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [LW-1:0]  ring_len,
  input logic           start_ack,
  input logic           start_fail,
  input logic [LGN-1:0] start_id,
  input logic [N-1:0]   run_mask,
  input logic           spare_en,
  input logic [N-1:0]   grant,
  input logic [LGN-1:0] slot_idx
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r3_owner_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(spare_en) && (grant != '0)) |-> grant[slot_idx]);

  a_r4_running_only: assert property (@(posedge clk) disable iff (rst)
    (grant & ~$past(run_mask)) == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (slot_idx != '0) |-> (slot_idx == $past(slot_idx) + LGN'(1)));

  a_r2_in_ring: assert property (@(posedge clk) disable iff (rst)
    {1'b0, slot_idx} < $past(ring_len));

  a_r5_ack_xor_fail: assert property (@(posedge clk) disable iff (rst)
    !(start_ack && start_fail));

  a_r6_ack_runs: assert property (@(posedge clk) disable iff (rst)
    start_ack |-> run_mask[start_id]);

  for (genvar g = 0; g < N; g++) begin : g_gap
    logic [SW-1:0] since;
    always_ff @(posedge clk) begin
      if (rst)                     since <= SW'(BUSY);
      else if (grant[g])           since <= SW'(1);
      else if (since < SW'(BUSY))  since <= since + SW'(1);
    end
    a_r11_spacing: assert property (@(posedge clk) disable iff (rst)
      grant[g] |-> (since >= SW'(BUSY)));
  end
endmodule

bind hub_ring_arb hub_ring_chk #(.LGN(LGN), .BUSY(BUSY)) u_chk (
  .clk(clk), .rst(rst), .ring_len(ring_len), .start_ack(start_ack),
  .start_fail(start_fail), .start_id(start_id), .run_mask(run_mask),
  .spare_en(spare_en), .grant(grant), .slot_idx(slot_idx)
);

// File: tb/sim_hub_ring_arb.sv
module sim_hub_ring_arb;
  localparam int LGN = 4;
  localparam int N   = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst, cfg_we, cfg_err, start_req, start_ack, start_fail;
  logic           stop_req, spare_en;
  logic [2:0]     cfg_code;
  logic [LGN:0]   ring_len;
  logic [LGN-1:0] start_id, stop_id, slot_idx;
  logic [N-1:0]   run_mask, hub_req, spare_mask, grant;

  hub_ring_arb #(.LGN(LGN), .BUSY(8)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  // {code[2:0], expected length[4:0]}
  localparam logic [7:0] VEC [8] = '{8'h01, 8'h22, 8'h44, 8'h68,
                                     8'h90, 8'hB0, 8'hD0, 8'hF0};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] code, output logic err);
    @(negedge clk); cfg_we = 1'b1; cfg_code = code;
    @(negedge clk); cfg_we = 1'b0; err = cfg_err;
  endtask

  task automatic do_start(output logic ack, output logic fail, output int id);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    ack = start_ack; fail = start_fail; id = int'(start_id);
  endtask

  task automatic do_stop(input int id);
    @(negedge clk); stop_req = 1'b1; stop_id = LGN'(id);
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic e, a, f;
    int id;
    rst = 1'b1; cfg_we = 1'b0; cfg_code = '0; start_req = 1'b0;
    stop_req = 1'b0; stop_id = '0; hub_req = '0; spare_en = 1'b0;
    spare_mask = '0;
    cyc(3);
    // R1 reset state
    chk("R1 ring_len", int'(ring_len), 16);
    chk("R1 run_mask", int'(run_mask), 1);
    chk("R1 slot_idx", int'(slot_idx), 0);
    chk("R1 grant", int'(grant), 0);
    rst = 1'b0;

    // R2/R7 table walk: every code with only core 0 running
    for (int k = 0; k < 8; k++) begin
      int mx;
      cfg_write(VEC[k][7:5], e);
      cyc(40);
      mx = 0;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (int'(slot_idx) > mx) mx = int'(slot_idx);
      end
      chk("R7 ring_len for code", int'(ring_len), int'(VEC[k][4:0]));
      chk("R2 slot max", mx, int'(VEC[k][4:0]) - 1);
    end

    // R5 lowest-free allocation at ring 16
    for (int s = 1; s < 4; s++) begin
      do_start(a, f, id);
      chk("R5 start ack", int'(a), 1);
      chk("R5 start id lowest free", id, s);
    end

    // shrink to 4 with cores 0..3 running: accepted
    cfg_write(3'd2, e);
    chk("R8 accepted write no err", int'(e), 0);
    cyc(40);
    chk("R9 ring_len applied", int'(ring_len), 4);

    do_start(a, f, id);
    chk("R5 start fail when full", int'(f), 1);
    chk("R5 no ack when full", int'(a), 0);

    // R8 stranding write refused
    cfg_write(3'd1, e);
    chk("R8 cfg_err pulse", int'(e), 1);
    cyc(40);
    chk("R8 ring_len unchanged", int'(ring_len), 4);

    // R6 stop frees id
    do_stop(2);
    chk("R6 run bit cleared", int'(run_mask[2]), 0);
    do_start(a, f, id);
    chk("R6 freed id reused", id, 2);

    // R3/R4/R11/R12 grant pattern at ring 4, cores 0..2 running
    do_stop(3);
    begin
      int cnt1, last, mingap, mism, outside;
      cnt1 = 0; last = -100; mingap = 1000; mism = 0; outside = 0;
      @(negedge clk); hub_req = '1;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (grant[1]) begin
          cnt1++;
          if (c - last < mingap) mingap = c - last;
          last = c;
        end
        if (grant[3] || grant[5]) outside++;
        if ((grant != '0) && (grant != (N'(1) << slot_idx))) mism++;
      end
      chk("R11 core1 grants in 32", cnt1, 4);
      chk("R11 core1 min gap", mingap, 8);
      chk("R4 stopped/outside never granted", outside, 0);
      chk("R3 R12 grant matches slot", mism, 0);
    end
    @(negedge clk); hub_req = '0;

    // R9 shrink from 8 to 4 takes effect only on wrap
    do_start(a, f, id);
    chk("R5 restart id 3", id, 3);
    cfg_write(3'd3, e);
    cyc(40);
    chk("R9 ring_len 8", int'(ring_len), 8);
    cfg_write(3'd2, e);
    begin
      int prev, bad;
      prev = int'(slot_idx); bad = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (slot_idx == '0) begin
          if (prev != 7 && prev != 3) bad++;
        end else if (int'(slot_idx) != prev + 1) bad++;
        prev = int'(slot_idx);
      end
      chk("R9 no shortened period", bad, 0);
      chk("R9 ring_len 4 after wrap", int'(ring_len), 4);
    end

    // R10 spare slots at ring 16
    cfg_write(3'd4, e);
    cyc(40);
    chk("R7 ring_len 16", int'(ring_len), 16);
    begin
      int c1, c2;
      @(negedge clk); hub_req = N'(1) << 2;
      c2 = 0;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (grant[2]) c2++;
      end
      chk("R10 spare off: own slot only", c2, 2);
      @(negedge clk); spare_en = 1'b1; spare_mask = N'(1) << 2;
      cyc(8);
      c2 = 0;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (grant[2]) c2++;
      end
      chk("R10 spare on: idle slots reused", c2, 4);
      @(negedge clk); hub_req = (N'(1) << 2) | (N'(1) << 1);
      cyc(8);
      c1 = 0; c2 = 0;
      for (int c = 0; c < 32; c++) begin
        @(negedge clk);
        if (grant[1]) c1++;
        if (grant[2]) c2++;
      end
      chk("R10 owner keeps its slot", c1, 2);
      chk("R10 spare core still served", c2, 4);
    end

    summary();
    $finish;
  end
endmodule